// File: doc/BRIEF.md
# ULPI Viewport Bridge

The bridge gives software access to the register file of an external ULPI transceiver through one packed 32-bit control word. One write to that word starts either a wakeup of a suspended PHY or a single register transfer with an immediate address. The bridge then runs the matching sequence on the 8-bit ULPI data bus using the DIR, NXT and STP lines. When the sequence ends, the bridge clears the self-clearing request bit. Software polls that bit to learn when the operation is done. For a read, the returned byte is placed in the same word.

The whole block runs on the PHY-supplied ULPI clock. A read-only sync flag in the word tells software whether the PHY has been seen in normal synchronous mode since reset. When the flag reads 0, software issues a wakeup before any register access. While a request is in flight, the bridge drops all further writes to the word. If the PHY takes the bus during the command phase, the transfer is retried without any action from software.

Top module: `ulpi_viewport_bridge`

## Requirements
- R1: After reset the wakeup bit (31), run bit (30) and direction bit (29) read 0, STP is low and the bridge does not drive the data bus.
- R2: The sync flag (bit 27) reads 0 after reset. It reads 1 from the cycle after DIR is first sampled low. It stays 1 until the next reset.
- R3: Writing 1 to bit 31 sets it. One cycle later STP goes high and stays high while DIR is high. In the cycle after DIR is sampled low, STP is released, bit 31 reads 0 and bit 27 reads 1. Bit 31 takes priority over bit 30 in the same write.
- R4: A write with bit 30 set and bit 31 clear starts a transfer. Bit 29 set means a register write and bit 29 clear means a register read. The PHY address comes from bits 23:16 and the write byte from bits 7:0. These fields read back unchanged while the transfer runs.
- R5: A register write drives the byte {2'b10, addr[5:0]} with the output enable high, and holds it until NXT is sampled high. It then drives the write byte for one cycle, then drives STP high for one cycle with the data bus at 0. Bit 30 reads 0 in the following cycle.
- R6: A register read drives {2'b11, addr[5:0]} until NXT is sampled high, then stops driving the bus. The byte is captured in the cycle after DIR is first sampled high; the turnaround cycle is not captured. Bit 30 stays 1 until DIR is sampled low. The captured byte then reads in bits 15:8.
- R7: If DIR is sampled high during the command phase before NXT, the bridge stops driving at once and bit 30 stays 1. The command is reissued once DIR is sampled low.
- R8: A write to the word while bit 30 or bit 31 is set has no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ULPI clock from the PHY |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the viewport word |
| reg_wdata_i | input | 32 | Value written to the viewport word |
| reg_rdata_o | output | 32 | Current viewport word |
| ulpi_dir_i | input | 1 | Bus direction from the PHY, 1 means the PHY drives |
| ulpi_nxt_i | input | 1 | PHY throttle / accept strobe |
| ulpi_data_i | input | 8 | Data bus value driven by the PHY |
| ulpi_data_o | output | 8 | Data bus value driven by the bridge |
| ulpi_data_oe_o | output | 1 | Output enable for ulpi_data_o |
| ulpi_stp_o | output | 1 | Stop line toward the PHY |

## Verification
The bench holds the command phase for several cycles without NXT. A bridge that moved on early would put the data byte on the bus before the PHY accepted the command. During a read it places a decoy byte on the bus in the turnaround cycle. A bridge that sampled one cycle early would return the decoy instead of the real byte. It raises DIR in the middle of a command. A bridge without retry would clear the run bit or hang. It also writes the word while a wakeup is running. A bridge without the busy guard would start a transfer or change the address field. The bench also checks that the sync flag rises only one cycle after DIR is sampled low following reset.

// File: rtl/ulpi_vp_pkg.sv
package ulpi_vp_pkg;
  localparam int unsigned VP_W      = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PHY_ADR_W = 6;
  // viewport word bit positions
  localparam int unsigned VP_WU     = 31;
  localparam int unsigned VP_RUN    = 30;
  localparam int unsigned VP_WR     = 29;
  localparam int unsigned VP_SYNC   = 27;
  localparam int unsigned VP_ADR_LSB = 16;
  localparam int unsigned VP_RD_LSB  = 8;
  localparam int unsigned VP_WD_LSB  = 0;
  // transmit command prefixes
  localparam logic [1:0] TXC_REGWR = 2'b10;
  localparam logic [1:0] TXC_REGRD = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_CMD, ST_DATA, ST_STOP, ST_RTURN, ST_RCAP, ST_RWAIT
  } seq_state_e;

  typedef struct packed {
    logic              wr;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] wdata;
  } xfer_req_t;
endpackage

// File: rtl/ulpi_vp_regs.sv
module ulpi_vp_regs
  import ulpi_vp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [VP_W-1:0]   wdata_i,
  input  logic              xfer_done_i,
  input  logic              wake_done_i,
  input  logic              rd_valid_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  input  logic              sync_i,
  output logic              wu_o,
  output logic              run_o,
  output xfer_req_t         req_o,
  output logic [VP_W-1:0]   rdata_o
);
  logic              wu_q, run_q;
  xfer_req_t         req_q;
  logic [BYTE_W-1:0] rd_q;
  logic              accept;

  assign accept = we_i && !wu_q && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wu_q  <= 1'b0;
      run_q <= 1'b0;
      req_q <= '0;
      rd_q  <= '0;
    end else begin
      if (accept) begin
        wu_q       <= wdata_i[VP_WU];
        run_q      <= wdata_i[VP_RUN] & ~wdata_i[VP_WU];
        req_q.wr   <= wdata_i[VP_WR];
        req_q.addr <= wdata_i[VP_ADR_LSB +: BYTE_W];
        req_q.wdata <= wdata_i[VP_WD_LSB +: BYTE_W];
      end else begin
        if (wake_done_i) wu_q  <= 1'b0;
        if (xfer_done_i) run_q <= 1'b0;
      end
      if (rd_valid_i) rd_q <= rd_byte_i;
    end
  end

  always_comb begin
    rdata_o                          = '0;
    rdata_o[VP_WU]                   = wu_q;
    rdata_o[VP_RUN]                  = run_q;
    rdata_o[VP_WR]                   = req_q.wr;
    rdata_o[VP_SYNC]                 = sync_i;
    rdata_o[VP_ADR_LSB +: BYTE_W]    = req_q.addr;
    rdata_o[VP_RD_LSB +: BYTE_W]     = rd_q;
    rdata_o[VP_WD_LSB +: BYTE_W]     = req_q.wdata;
  end

  assign wu_o  = wu_q;
  assign run_o = run_q;
  assign req_o = req_q;
endmodule

// File: rtl/ulpi_vp_seq.sv
module ulpi_vp_seq
  import ulpi_vp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wu_i,
  input  logic              run_i,
  input  xfer_req_t         req_i,
  input  logic              dir_i,
  input  logic              nxt_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              oe_o,
  output logic              stp_o,
  output logic              xfer_done_o,
  output logic              wake_done_o,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              sync_o
);
  seq_state_e        state_q, state_d;
  logic [BYTE_W-1:0] rd_q;
  logic              sync_q;
  logic              link_drives;
  logic [BYTE_W-PHY_ADR_W-1:0] unused_addr_hi;

  assign unused_addr_hi = req_i.addr[BYTE_W-1:PHY_ADR_W];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (wu_i) state_d = ST_WAKE;
                else if (run_i && !dir_i) state_d = ST_CMD;
      ST_WAKE:  if (!dir_i) state_d = ST_IDLE;
      ST_CMD:   if (dir_i) state_d = ST_IDLE;            // PHY took the bus: retry later
                else if (nxt_i) state_d = req_i.wr ? ST_DATA : ST_RTURN;
      ST_DATA:  state_d = ST_STOP;
      ST_STOP:  state_d = ST_IDLE;
      ST_RTURN: if (dir_i) state_d = ST_RCAP;
      ST_RCAP:  state_d = ST_RWAIT;
      ST_RWAIT: if (!dir_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rd_q    <= '0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RCAP) rd_q <= data_i;
      if (!dir_i) sync_q <= 1'b1;
    end
  end

  assign link_drives = (state_q == ST_CMD) || (state_q == ST_DATA) || (state_q == ST_STOP);
  assign oe_o        = link_drives && !dir_i;

  always_comb begin
    data_o = '0;
    case (state_q)
      ST_CMD:  data_o = {(req_i.wr ? TXC_REGWR : TXC_REGRD), req_i.addr[PHY_ADR_W-1:0]};
      ST_DATA: data_o = req_i.wdata;
      default: data_o = '0;
    endcase
  end

  assign stp_o       = (state_q == ST_WAKE) || (state_q == ST_STOP);
  assign wake_done_o = (state_q == ST_WAKE) && !dir_i;
  assign rd_valid_o  = (state_q == ST_RWAIT) && !dir_i;
  assign xfer_done_o = (state_q == ST_STOP) || rd_valid_o;
  assign rd_byte_o   = rd_q;
  assign sync_o      = sync_q;
endmodule

// File: rtl/ulpi_viewport_bridge.sv
module ulpi_viewport_bridge
  import ulpi_vp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [VP_W-1:0]   reg_wdata_i,
  output logic [VP_W-1:0]   reg_rdata_o,
  input  logic              ulpi_dir_i,
  input  logic              ulpi_nxt_i,
  input  logic [BYTE_W-1:0] ulpi_data_i,
  output logic [BYTE_W-1:0] ulpi_data_o,
  output logic              ulpi_data_oe_o,
  output logic              ulpi_stp_o
);
  logic              wu, run, xfer_done, wake_done, rd_valid, sync;
  logic [BYTE_W-1:0] rd_byte;
  xfer_req_t         req;

  ulpi_vp_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .xfer_done_i (xfer_done),
    .wake_done_i (wake_done),
    .rd_valid_i  (rd_valid),
    .rd_byte_i   (rd_byte),
    .sync_i      (sync),
    .wu_o        (wu),
    .run_o       (run),
    .req_o       (req),
    .rdata_o     (reg_rdata_o)
  );

  ulpi_vp_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wu_i        (wu),
    .run_i       (run),
    .req_i       (req),
    .dir_i       (ulpi_dir_i),
    .nxt_i       (ulpi_nxt_i),
    .data_i      (ulpi_data_i),
    .data_o      (ulpi_data_o),
    .oe_o        (ulpi_data_oe_o),
    .stp_o       (ulpi_stp_o),
    .xfer_done_o (xfer_done),
    .wake_done_o (wake_done),
    .rd_valid_o  (rd_valid),
    .rd_byte_o   (rd_byte),
    .sync_o      (sync)
  );
endmodule

// File: rtl/ulpi_vp_checker.sv
module ulpi_vp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [31:0] reg_rdata_o,
  input logic        ulpi_dir_i,
  input logic        ulpi_data_oe_o,
  input logic        ulpi_stp_o,
  input logic [7:0]  ulpi_data_o,
  input logic        xfer_done_i
);
  AST_WAKE_STP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31] && $past(reg_rdata_o[31])) |-> ulpi_stp_o);                    // R3
  AST_STP_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ulpi_stp_o |-> (ulpi_data_o == 8'h00));                                          // R5
  AST_RUN_CLEAR_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_rdata_o[30]) |-> $past(xfer_done_i));                                  // R7
  AST_NO_DRIVE_PHY_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ulpi_dir_i && $past(ulpi_dir_i)) |-> !ulpi_data_oe_o);                           // R6
  AST_SYNC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_rdata_o[27]) |-> reg_rdata_o[27]);                                      // R2
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_rdata_o[31] || reg_rdata_o[30])) |=> $stable(reg_rdata_o[23:16])); // R8
endmodule

bind ulpi_viewport_bridge ulpi_vp_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_we_i       (reg_we_i),
  .reg_rdata_o    (reg_rdata_o),
  .ulpi_dir_i     (ulpi_dir_i),
  .ulpi_data_oe_o (ulpi_data_oe_o),
  .ulpi_stp_o     (ulpi_stp_o),
  .ulpi_data_o    (ulpi_data_o),
  .xfer_done_i    (xfer_done)
);

// File: tb/ulpi_viewport_bridge_tb.sv
module ulpi_viewport_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dir = 1'b1;
  logic        nxt = 1'b0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        oe, stp;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  ulpi_viewport_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ulpi_dir_i(dir), .ulpi_nxt_i(nxt), .ulpi_data_i(din),
    .ulpi_data_o(dout), .ulpi_data_oe_o(oe), .ulpi_stp_o(stp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [31:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_cmd(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (oe && dout[7:6] != 2'b00) begin seen = 1'b1; break; end
    end
  endtask

  task automatic t_reset_dir_high();
    rst_n = 1'b0; dir = 1'b1; nxt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl bits", {29'd0, rdata[31:29]}, 32'd0);
    chk("R1 stp", {31'd0, stp}, 32'd0);
    chk("R1 oe", {31'd0, oe}, 32'd0);
    chk("R2 sync low while dir high", {31'd0, rdata[27]}, 32'd0);
  endtask

  task automatic t_wakeup();
    cpu_wr(32'h8000_0000);
    @(negedge clk);
    chk("R3 stp raised", {31'd0, stp}, 32'd1);
    chk("R3 wu set", {31'd0, rdata[31]}, 32'd1);
    cpu_wr(32'h4035_00AA);     // busy: must be dropped
    chk("R8 run not started", {31'd0, rdata[30]}, 32'd0);
    chk("R8 addr unchanged", {24'd0, rdata[23:16]}, 32'd0);
    chk("R8 wdata unchanged", {24'd0, rdata[7:0]}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R3 stp held", {31'd0, stp}, 32'd1);
    dir = 1'b0;
    @(negedge clk);
    chk("R3 stp released", {31'd0, stp}, 32'd0);
    chk("R3 wu cleared", {31'd0, rdata[31]}, 32'd0);
    chk("R3 sync set", {31'd0, rdata[27]}, 32'd1);
  endtask

  task automatic t_regwrite(input logic [7:0] addr, input logic [7:0] d);
    bit seen;
    cpu_wr({3'b011, 5'd0, addr, 8'h00, d});
    chk("R4 run/dir", {29'd0, rdata[31:29]}, 32'd3);
    chk("R4 fields", {16'd0, rdata[23:16], rdata[7:0]}, {16'd0, addr, d});
    wait_cmd(seen);
    chk("R5 cmd seen", {31'd0, seen}, 32'd1);
    chk("R5 cmd byte", {24'd0, dout}, {24'd0, 2'b10, addr[5:0]});
    cpu_wr({3'b010, 5'd0, ~addr, 16'h0}); // busy: must be dropped
    chk("R8 addr kept", {24'd0, rdata[23:16]}, {24'd0, addr});
    chk("R5 cmd held", {23'd0, oe, dout}, {23'd0, 1'b1, 2'b10, addr[5:0]});
    nxt = 1'b1;
    @(negedge clk); nxt = 1'b0;
    chk("R5 data byte", {23'd0, oe, dout}, {23'd0, 1'b1, d});
    @(negedge clk);
    chk("R5 stp with zero bus", {22'd0, stp, oe, dout}, {22'd0, 2'b11, 8'h00});
    @(negedge clk);
    chk("R5 stp low, run clear", {30'd0, stp, rdata[30]}, 32'd0);
  endtask

  task automatic t_regread(input logic [7:0] addr, input logic [7:0] b);
    bit seen;
    cpu_wr({3'b010, 5'd0, addr, 16'h0000});
    chk("R4 read dir bit", {29'd0, rdata[31:29]}, 32'd2);
    wait_cmd(seen);
    chk("R6 cmd byte", {24'd0, dout}, {24'd0, 2'b11, addr[5:0]});
    nxt = 1'b1;
    @(negedge clk); nxt = 1'b0; dir = 1'b1; din = ~b; // decoy in turnaround
    chk("R6 bus released", {31'd0, oe}, 32'd0);
    @(negedge clk); din = b;
    @(negedge clk); din = 8'h00;
    chk("R6 run held while dir high", {31'd0, rdata[30]}, 32'd1);
    @(negedge clk); dir = 1'b0;
    chk("R6 still busy", {31'd0, rdata[30]}, 32'd1);
    @(negedge clk);
    chk("R6 run clear", {31'd0, rdata[30]}, 32'd0);
    chk("R6 read byte", {24'd0, rdata[15:8]}, {24'd0, b});
  endtask

  task automatic t_abort(input logic [7:0] addr, input logic [7:0] d);
    bit seen;
    cpu_wr({3'b011, 5'd0, addr, 8'h00, d});
    wait_cmd(seen);
    dir = 1'b1;
    @(negedge clk);
    chk("R7 bus released on abort", {31'd0, oe}, 32'd0);
    chk("R7 run kept", {31'd0, rdata[30]}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R7 no drive while dir high", {31'd0, oe}, 32'd0);
    dir = 1'b0;
    wait_cmd(seen);
    chk("R7 cmd reissued", {23'd0, seen, dout}, {23'd0, 1'b1, 2'b10, addr[5:0]});
    nxt = 1'b1;
    @(negedge clk); nxt = 1'b0;
    chk("R7 data after retry", {24'd0, dout}, {24'd0, d});
    repeat (2) @(negedge clk);
    chk("R7 run clear after retry", {31'd0, rdata[30]}, 32'd0);
  endtask

  task automatic t_reset_dir_low();
    @(negedge clk); rst_n = 1'b0; dir = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R2 sync zero before edge", {31'd0, rdata[27]}, 32'd0);
    @(negedge clk);
    chk("R2 sync after dir low", {31'd0, rdata[27]}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset_dir_high();
    t_wakeup();
    t_regwrite(8'h15, 8'hA5);
    t_regwrite(8'h3F, 8'h00);
    t_regread(8'h2A, 8'h5C);
    t_regread(8'h01, 8'hFF);
    t_abort(8'h0A, 8'h3C);
    t_reset_dir_low();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule